// File: doc/BRIEF.md
# PUF Response Quality Metric Unit

This block measures the quality of a power-up response read from an SRAM array used as a physically unclonable function. The response arrives one 64-bit word at a time over a valid/ready input. Row data words are taken in address order, so together they form a single one-dimensional bit string. For each accepted word the unit forms three popcounts and adds each to its own running count. The first is the number of bits that differ from the matching enrollment word, which gives the within-class distance. The second is the number of ones left after the word is XORed with a bias-mask word, which gives the masked weight. The third is the plain number of ones, which gives the raw weight. A fourth count holds the total number of bits seen, so software can form each metric as a fraction.

The enrollment word and the mask word arrive on their own inputs in lockstep with the response word. The mask store is outside the block. The unit drives a word index into that store. The index first walks through a programmable number of prefix words. It then cycles through a programmable number of periodic words. This covers a bias pattern that opens with a distinct segment, for example a stretch skewed toward zero, and then repeats with a fixed period. A clear pulse starts a new measurement. A word flagged as last closes it: a done flag rises, and the counts are frozen until the next clear.

Top module: `puf_quality_meter`

## Requirements
- R1: After reset all four counts and the mask index are 0, done is low and the input is ready.
- R2: On the clock edge that accepts a word, the distance count grows by the number of bit positions where the word differs from the enrollment word presented with it.
- R3: On that same edge, the masked count grows by the number of ones in the word XORed with the mask word presented with it.
- R4: On that same edge, the raw count grows by the number of ones in the word.
- R5: On that same edge, the bit count grows by 64, the word width.
- R6: The mask index starts at 0 and advances by one per accepted word. When it reaches prefix + period - 1, or any value above that, it returns to the prefix value instead of advancing. A period of 0 holds the index where it is.
- R7: Done rises on the edge that accepts a word with last set. While done is high, ready is low, offered words are ignored and every output holds.
- R8: A clear zeroes all counts and the index and drops done on the next edge. During the clear cycle ready is low, so a word offered then is not counted.
- R9: A cycle with valid low changes no count and does not move the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start/clear pulse for a new measurement |
| cfg_prefix_i | input | 8 | Number of prefix mask words before the periodic part |
| cfg_period_i | input | 8 | Number of words in the periodic part of the mask |
| in_valid_i | input | 1 | Response word valid |
| in_ready_o | output | 1 | Block can accept a word |
| in_word_i | input | 64 | Response word |
| in_last_i | input | 1 | Marks the final word of the response |
| enroll_word_i | input | 64 | Enrollment word matching the current response word |
| mask_word_i | input | 64 | Mask word read at mask_idx_o |
| mask_idx_o | output | 8 | Index of the mask word needed for the next accepted word |
| done_o | output | 1 | Measurement complete; counts are final |
| wchd_o | output | 32 | Differing-bit count against enrollment |
| mhw_o | output | 32 | Ones count after masking |
| hw_o | output | 32 | Plain ones count |
| bits_o | output | 32 | Total bits accepted |

## Verification
Every count, the mask index and the done flag change on the first clock edge after the cycle in which a word is accepted. That is one register stage, with no delay between the popcount and the accumulator. Ready is combinational and follows done and clear within the same cycle. The bench sets inputs at the falling edge. It checks ready in that same half cycle, before the rising edge. At the next falling edge it compares all outputs with a behavioural model that has applied exactly the words it expected to be accepted. This keeps each comparison exactly one edge after its stimulus.

// File: rtl/puf_qm_pkg.sv
package puf_qm_pkg;
  localparam int WORD_W_DEF = 64;
  localparam int CNT_W_DEF  = 32;
  localparam int IDX_W_DEF  = 8;

  typedef enum int {
    MET_DIST   = 0,
    MET_MASKED = 1,
    MET_RAW    = 2
  } metric_e;

  localparam int NUM_METRICS = 3;
endpackage

// File: rtl/puf_popcount.sv
module puf_popcount #(
  parameter int W  = 64,
  localparam int LV = $clog2(W),
  localparam int CW = LV + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  initial begin
    assert (W == (1 << LV)) else $error("popcount width must be a power of two");
  end

  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int N = W >> l;
    logic [CW-1:0] s [N];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < N; i++) begin : g_bit
        assign s[i] = CW'(vec_i[i]);
      end
    end else begin : g_node
      for (genvar j = 0; j < N; j++) begin : g_add
        assign s[j] = g_lvl[l-1].s[2*j] + g_lvl[l-1].s[2*j+1];
      end
    end
  end

  assign cnt_o = g_lvl[LV].s[0];
endmodule

// File: rtl/puf_metric_acc.sv
module puf_metric_acc #(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             add_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear_i | add_i;
    cnt_d  = clear_i ? '0 : cnt_q + CNT_W'(inc_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_acc_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_o == '0));
  assert_acc_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !add_i) |=> $stable(cnt_o));
endmodule

// File: rtl/puf_mask_indexer.sv
module puf_mask_indexer #(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] prefix_i,
  input  logic [IDX_W-1:0] period_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W:0]   last_w;
  logic             at_end;
  logic             idx_en;

  always_comb begin
    last_w = {1'b0, prefix_i} + {1'b0, period_i} - 1'b1;
    at_end = ({1'b0, idx_q} >= last_w);
    idx_en = clear_i | (step_i & (period_i != '0));
    if (clear_i)     idx_d = '0;
    else if (at_end) idx_d = prefix_i;
    else             idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  assert_idx_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (idx_o == '0));
  assert_idx_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && period_i != '0 &&
     ({1'b0, idx_o} >= ({1'b0, prefix_i} + {1'b0, period_i} - 1'b1)))
    |=> (idx_o == $past(prefix_i)));
  assert_idx_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> $stable(idx_o));
endmodule

// File: rtl/puf_quality_meter.sv
module puf_quality_meter
  import puf_qm_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  parameter int IDX_W  = IDX_W_DEF,
  localparam int PC_W  = $clog2(WORD_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [IDX_W-1:0]  cfg_prefix_i,
  input  logic [IDX_W-1:0]  cfg_period_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic              in_last_i,
  input  logic [WORD_W-1:0] enroll_word_i,
  input  logic [WORD_W-1:0] mask_word_i,
  output logic [IDX_W-1:0]  mask_idx_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  wchd_o,
  output logic [CNT_W-1:0]  mhw_o,
  output logic [CNT_W-1:0]  hw_o,
  output logic [CNT_W-1:0]  bits_o
);
  logic done_q, done_d, done_en;
  logic accept;

  logic [WORD_W-1:0] opnd  [NUM_METRICS];
  logic [PC_W-1:0]   pcnt  [NUM_METRICS];
  logic [CNT_W-1:0]  mcnt  [NUM_METRICS];

  assign in_ready_o = ~done_q & ~clear_i;
  assign accept     = in_valid_i & in_ready_o;

  always_comb begin
    done_en = clear_i | accept;
    done_d  = clear_i ? 1'b0 : in_last_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      done_q <= 1'b0;
    else if (done_en) done_q <= done_d;
  end

  assign opnd[MET_DIST]   = in_word_i ^ enroll_word_i;
  assign opnd[MET_MASKED] = in_word_i ^ mask_word_i;
  assign opnd[MET_RAW]    = in_word_i;

  for (genvar m = 0; m < NUM_METRICS; m++) begin : g_met
    puf_popcount #(.W(WORD_W)) u_pc (
      .vec_i (opnd[m]),
      .cnt_o (pcnt[m])
    );
    puf_metric_acc #(.CNT_W(CNT_W), .INC_W(PC_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .add_i   (accept),
      .inc_i   (pcnt[m]),
      .cnt_o   (mcnt[m])
    );
  end

  puf_metric_acc #(.CNT_W(CNT_W), .INC_W(PC_W)) u_bits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .add_i   (accept),
    .inc_i   (PC_W'(WORD_W)),
    .cnt_o   (bits_o)
  );

  puf_mask_indexer #(.IDX_W(IDX_W)) u_idx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .step_i   (accept),
    .prefix_i (cfg_prefix_i),
    .period_i (cfg_period_i),
    .idx_o    (mask_idx_o)
  );

  assign wchd_o = mcnt[MET_DIST];
  assign mhw_o  = mcnt[MET_MASKED];
  assign hw_o   = mcnt[MET_RAW];
  assign done_o = done_q;

  assert_done_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_last_i) |=> done_o);
  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> (done_o && $stable(bits_o) && $stable(wchd_o)));
  assert_no_ready_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !in_ready_o);
  assert_bits_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (bits_o == $past(bits_o) + CNT_W'(WORD_W)));
  assert_dist_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i) |=> (wchd_o - $past(wchd_o) <= CNT_W'(WORD_W)));
endmodule

// File: tb/puf_quality_meter_tb.sv
module puf_quality_meter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        clear_i;
  logic [7:0]  cfg_prefix_i, cfg_period_i;
  logic        in_valid_i, in_ready_o, in_last_i, done_o;
  logic [63:0] in_word_i, enroll_word_i, mask_word_i;
  logic [7:0]  mask_idx_o;
  logic [31:0] wchd_o, mhw_o, hw_o, bits_o;

  logic [63:0] mask_rom   [16];
  logic [63:0] enroll_rom [32];

  longint e_wchd, e_mhw, e_hw, e_bits;
  int     e_idx, widx;
  bit     e_done;
  int     checks = 0, fails = 0;

  always #2 clk_i = ~clk_i;

  assign mask_word_i = mask_rom[mask_idx_o[3:0]];

  puf_quality_meter u_dut (
    .clk_i, .rst_ni, .clear_i, .cfg_prefix_i, .cfg_period_i,
    .in_valid_i, .in_ready_o, .in_word_i, .in_last_i,
    .enroll_word_i, .mask_word_i, .mask_idx_o, .done_o,
    .wchd_o, .mhw_o, .hw_o, .bits_o
  );

  function automatic int pop(logic [63:0] v);
    int n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk({req, " R2 wchd"}, longint'(wchd_o), e_wchd);
    chk({req, " R3 mhw"},  longint'(mhw_o),  e_mhw);
    chk({req, " R4 hw"},   longint'(hw_o),   e_hw);
    chk({req, " R5 bits"}, longint'(bits_o), e_bits);
    chk({req, " R6 idx"},  longint'(mask_idx_o), longint'(e_idx));
    chk({req, " R7 done"}, longint'(done_o), longint'(e_done));
  endtask

  // Called just after a falling edge: drives one cycle, models it, checks at next falling edge.
  task automatic step(bit v, bit l, bit clr, logic [63:0] w, string req);
    bit exp_ready, acc;
    int last;
    clear_i = clr; in_valid_i = v; in_last_i = l; in_word_i = w;
    enroll_word_i = enroll_rom[widx % 32];
    #1;
    exp_ready = !e_done && !clr;
    chk({req, " R7/R8 ready"}, longint'(in_ready_o), longint'(exp_ready));
    acc = v && exp_ready;
    if (clr) begin
      e_wchd = 0; e_mhw = 0; e_hw = 0; e_bits = 0; e_idx = 0; e_done = 0; widx = 0;
    end else if (acc) begin
      e_wchd += pop(w ^ enroll_rom[widx % 32]);
      e_mhw  += pop(w ^ mask_rom[e_idx % 16]);
      e_hw   += pop(w);
      e_bits += 64;
      widx++;
      if (cfg_period_i != 0) begin
        last = int'(cfg_prefix_i) + int'(cfg_period_i) - 1;
        e_idx = (e_idx >= last) ? int'(cfg_prefix_i) : e_idx + 1;
      end
      e_done = l;
    end
    @(negedge clk_i);
    compare_all(req);
  endtask

  task automatic new_run(int pre, int per);
    cfg_prefix_i = 8'(pre); cfg_period_i = 8'(per);
    step(1'b1, 1'b0, 1'b1, 64'hFFFF, "R8 clear with valid");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mask_rom[i] = {$urandom, $urandom};
    for (int i = 0; i < 32; i++) enroll_rom[i] = {$urandom, $urandom};
    rst_ni = 1'b0; clear_i = 0; in_valid_i = 0; in_last_i = 0;
    in_word_i = '0; enroll_word_i = '0; cfg_prefix_i = 8'd1; cfg_period_i = 8'd2;
    e_wchd = 0; e_mhw = 0; e_hw = 0; e_bits = 0; e_idx = 0; e_done = 0; widx = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    compare_all("R1 reset");
    chk("R1 ready after reset", longint'(in_ready_o), 1);

    // Run 1: prefix 1, period 2, random words with random gaps (R9 on idle cycles).
    for (int k = 0; k < 20; ) begin
      bit v = ($urandom % 4) != 0;
      step(v, v && (k == 19), 1'b0, {$urandom, $urandom}, v ? "R2-run1" : "R9 idle");
      if (v) k++;
    end
    // Offers while done must be ignored (R7).
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0, '1, "R7 ignored");

    // Run 2: prefix 0, period 3, response equal to enrollment (zero distance).
    new_run(0, 3);
    for (int k = 0; k < 10; k++) begin
      in_word_i = enroll_rom[widx % 32];
      step(1'b1, k == 9, 1'b0, enroll_rom[widx % 32], "R2 zero distance");
    end
    chk("R2 zero distance total", longint'(wchd_o), 0);

    // Run 3: prefix 3, period 1, all-ones and all-zero words.
    new_run(3, 1);
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b0, (k % 2) ? '1 : '0, "R4 extremes");
    step(1'b0, 1'b0, 1'b1, '0, "R8 clear mid-stream");
    chk("R8 cleared bits", longint'(bits_o), 0);

    // Run 4: period 0 holds index.
    new_run(2, 0);
    for (int k = 0; k < 5; k++) step(1'b1, k == 4, 1'b0, {$urandom, $urandom}, "R6 period zero");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule